// File: doc/BRIEF.md
# DMA Channel Register File

This block is the register side of a descriptor-driven DMA engine. It holds, for every channel, a status word, a command pointer and three condition-select words, plus a few spare words. All of these sit behind a word-only 32-bit register bus. A 4 KB window is split into 32 channel slices of 128 bytes each. Within a slice, the word index is taken from byte offset bits 5:2.

Software starts, pauses, wakes and stops a channel through a control word. The upper half of that word carries a per-bit mask for the lower half. After the merge, the block derives the ACTIVE and DEAD status flags.

Writing the command pointer of an idle channel aligns it to 16 bytes and emits a one-cycle fetch request to the descriptor executor. A control write that leaves a channel active emits a one-cycle start pulse, tagged with the drain (FLUSH) bit. The executor may kill a channel at any time, which marks it dead and raises an interrupt pulse.

Top module: `dma_chan_regs`

## Requirements
- R1: After a synchronous active-low reset, every register of every channel reads zero, and no fetch, start or interrupt pulse is present.
- R2: A write to index 0 (control) merges into the 16-bit status as (value AND settable AND mask) OR (old AND NOT mask). The mask is write data bits 31:16 and the value is bits 15:0. Status layout: RUN bit 15, PAUSE bit 14, FLUSH bit 13, WAKE bit 12, DEAD bit 11, ACTIVE bit 10, BT bit 8, device bits 7:0. Only RUN, PAUSE, FLUSH, WAKE and the device bits are settable.
- R3: After the merge these steps apply in order. WAKE set forces ACTIVE. RUN set forces ACTIVE and clears DEAD. PAUSE set clears ACTIVE.
- R4: A control write that takes RUN from 1 to 0 clears both ACTIVE and DEAD.
- R5: A read returns its data with a one-cycle valid strobe on the cycle after the request. The read-back rules are:
  - index 0 (control) and indices 2, 7, 8, 9, 11 and 12 read zero;
  - indices 3 (pointer), 4, 5, 6 (selects) and the spare indices 10, 13, 14, 15 read back what was stored;
  - index 1 reads the status in bits 15:0, with zero above.
- R6: A write to index 3 (command pointer) is ignored while RUN or ACTIVE is set. The stored pointer is unchanged and no fetch request is issued.
- R7: An accepted pointer write stores the data with bits 3:0 cleared. On the next cycle it pulses the fetch request, carrying the channel number and the aligned pointer.
- R8: A control write whose resulting status has ACTIVE set pulses the start output on the next cycle. The pulse carries the channel number, and the drain flag equals the resulting FLUSH bit.
- R9: A kill request sets DEAD and clears ACTIVE in the named channel and pulses the interrupt output with that channel number on the next cycle. When a kill and a bus write hit the same channel in one cycle, the kill is applied after the write and no start pulse is issued.
- R10: The channel is taken from address bits 11:7. An access with address bit 6 set, or with bits 1:0 non-zero, is unmapped: it writes nothing and reads zero. Channels never affect one another.
- R11: A direct write to index 1 stores write data bits 15:0 as the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after bus_rd |
| kill_req | input | 1 | Kill request from the executor |
| kill_ch | input | 5 | Channel to kill |
| irq_pulse | output | 1 | Interrupt pulse caused by a kill |
| irq_ch | output | 5 | Channel of the interrupt pulse |
| fetch_req | output | 1 | Descriptor fetch request pulse |
| fetch_ch | output | 5 | Channel of the fetch request |
| fetch_ptr | output | 32 | Aligned command pointer to fetch from |
| start_pulse | output | 1 | Channel became or stayed active after a control write |
| start_flush | output | 1 | Drain requested with the start pulse |
| start_ch | output | 5 | Channel of the start pulse |

## Verification
The two functions that can meet in a single cycle are a control write from the bus and a kill from the executor, since both rewrite the same status word.

The bench drives both in the same clock. In one case they target the same channel and the write sets RUN: the channel must end with DEAD set and ACTIVE clear, the interrupt must pulse, and no start pulse may appear. In the other case they target two different channels: the written channel must start normally while the other is killed, showing that the two updates do not interfere.

// File: rtl/dma_chan_regs_pkg.sv
// Package: register indices, status bit positions and the settable-bit mask
// shared by the channel register file and its checker.
package dma_chan_regs_pkg;

    localparam int WORD_W = 32;
    localparam int STAT_W = 16;
    localparam int IDX_W  = 4;

    // Word indices inside one channel slice
    localparam logic [IDX_W-1:0] RI_CTRL     = 4'd0;
    localparam logic [IDX_W-1:0] RI_STAT     = 4'd1;
    localparam logic [IDX_W-1:0] RI_PTR      = 4'd3;
    localparam logic [IDX_W-1:0] RI_IRQ_SEL  = 4'd4;
    localparam logic [IDX_W-1:0] RI_BR_SEL   = 4'd5;
    localparam logic [IDX_W-1:0] RI_WAIT_SEL = 4'd6;
    localparam logic [IDX_W-1:0] RI_SPARE_A  = 4'd10;
    localparam logic [IDX_W-1:0] RI_SPARE_B  = 4'd13;
    localparam logic [IDX_W-1:0] RI_SPARE_C  = 4'd14;
    localparam logic [IDX_W-1:0] RI_SPARE_D  = 4'd15;

    // Status bit positions
    localparam int SB_RUN    = 15;
    localparam int SB_PAUSE  = 14;
    localparam int SB_FLUSH  = 13;
    localparam int SB_WAKE   = 12;
    localparam int SB_DEAD   = 11;
    localparam int SB_ACTIVE = 10;

    // Bits a control write is allowed to set
    localparam logic [STAT_W-1:0] SETTABLE = 16'hF0FF;

    localparam int NUM_SEL   = 3;
    localparam int NUM_SPARE = 4;

endpackage

// File: rtl/dma_chreg_decode.sv
// Module: dma_chreg_decode
// Splits a window byte address into channel number and word index.
// Assumes word-only access: a misaligned address, or an offset in the upper
// half of the channel slice, is reported as unmapped.
module dma_chreg_decode
    import dma_chan_regs_pkg::*;
#(
    parameter int CH_W  = 5,
    parameter int OFS_W = 7
) (
    input  logic [CH_W+OFS_W-1:0] addr,
    output logic [CH_W-1:0]       ch,
    output logic [IDX_W-1:0]      idx,
    output logic                  mapped
);

    // Field extraction and mapping check
    always_comb begin
        ch     = addr[CH_W+OFS_W-1:OFS_W];
        idx    = addr[IDX_W+1:2];
        mapped = ~|addr[OFS_W-1:IDX_W+2] & ~|addr[1:0];
    end

endmodule

// File: rtl/dma_chreg_merge.sv
// Module: dma_chreg_merge
// Applies a masked control write to a status word, then derives ACTIVE and
// DEAD from WAKE, RUN, PAUSE and a falling RUN. Purely combinational.
module dma_chreg_merge
    import dma_chan_regs_pkg::*;
(
    input  logic [STAT_W-1:0] old_status,
    input  logic [STAT_W-1:0] mask,
    input  logic [STAT_W-1:0] value,
    output logic [STAT_W-1:0] new_status
);

    // Merge, then apply the derivation steps in their fixed order
    always_comb begin
        new_status = (value & SETTABLE & mask) | (old_status & ~mask);
        if (new_status[SB_WAKE]) begin
            new_status[SB_ACTIVE] = 1'b1;
        end
        if (new_status[SB_RUN]) begin
            new_status[SB_ACTIVE] = 1'b1;
            new_status[SB_DEAD]   = 1'b0;
        end
        if (new_status[SB_PAUSE]) begin
            new_status[SB_ACTIVE] = 1'b0;
        end
        if (old_status[SB_RUN] && !new_status[SB_RUN]) begin
            new_status[SB_ACTIVE] = 1'b0;
            new_status[SB_DEAD]   = 1'b0;
        end
    end

endmodule

// File: rtl/dma_chreg_slot.sv
// Module: dma_chreg_slot
// Register storage for one channel: status, command pointer, selects and
// spares. Produces its read word for a shared index and flags for fetch and
// start events. Assumes at most one write per cycle; a kill is applied after
// that write.
module dma_chreg_slot
    import dma_chan_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              kill,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic              fetch_o,
    output logic              start_o,
    output logic              flush_o
);

    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] status_d;
    logic [STAT_W-1:0] merged;
    logic [WORD_W-1:0] ptr_q;
    logic [WORD_W-1:0] sel_q   [NUM_SEL];
    logic [WORD_W-1:0] spare_q [NUM_SPARE];
    logic              ctrl_wr;
    logic              ptr_free;

    dma_chreg_merge u_merge (
        .old_status (status_q),
        .mask       (wdata[WORD_W-1:STAT_W]),
        .value      (wdata[STAT_W-1:0]),
        .new_status (merged)
    );

    // Next status: control merge or direct write, then kill on top
    always_comb begin
        ctrl_wr  = wr_en && (wr_idx == RI_CTRL);
        status_d = status_q;
        if (ctrl_wr) begin
            status_d = merged;
        end else if (wr_en && (wr_idx == RI_STAT)) begin
            status_d = wdata[STAT_W-1:0];
        end
        if (kill) begin
            status_d[SB_DEAD]   = 1'b1;
            status_d[SB_ACTIVE] = 1'b0;
        end
    end

    // Event flags for the top-level pulse registers
    always_comb begin
        ptr_free = !(status_q[SB_RUN] || status_q[SB_ACTIVE]);
        fetch_o  = wr_en && (wr_idx == RI_PTR) && ptr_free;
        start_o  = ctrl_wr && status_d[SB_ACTIVE];
        flush_o  = status_d[SB_FLUSH];
    end

    // Register storage update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            ptr_q    <= '0;
            for (int i = 0; i < NUM_SEL; i++) sel_q[i] <= '0;
            for (int i = 0; i < NUM_SPARE; i++) spare_q[i] <= '0;
        end else begin
            status_q <= status_d;
            if (fetch_o) ptr_q <= {wdata[WORD_W-1:4], 4'b0000};
            if (wr_en) begin
                case (wr_idx)
                    RI_IRQ_SEL:  sel_q[0]   <= wdata;
                    RI_BR_SEL:   sel_q[1]   <= wdata;
                    RI_WAIT_SEL: sel_q[2]   <= wdata;
                    RI_SPARE_A:  spare_q[0] <= wdata;
                    RI_SPARE_B:  spare_q[1] <= wdata;
                    RI_SPARE_C:  spare_q[2] <= wdata;
                    RI_SPARE_D:  spare_q[3] <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // Read-back selection; unlisted indices read zero
    always_comb begin
        case (rd_idx)
            RI_STAT:     rd_word = {{(WORD_W-STAT_W){1'b0}}, status_q};
            RI_PTR:      rd_word = ptr_q;
            RI_IRQ_SEL:  rd_word = sel_q[0];
            RI_BR_SEL:   rd_word = sel_q[1];
            RI_WAIT_SEL: rd_word = sel_q[2];
            RI_SPARE_A:  rd_word = spare_q[0];
            RI_SPARE_B:  rd_word = spare_q[1];
            RI_SPARE_C:  rd_word = spare_q[2];
            RI_SPARE_D:  rd_word = spare_q[3];
            default:     rd_word = '0;
        endcase
    end

endmodule

// File: rtl/dma_chan_regs.sv
// Module: dma_chan_regs
// Per-channel control/status register file of a descriptor DMA engine.
// Assumes a word-only register bus, at most one write per cycle, and kill
// requests from the executor. Every pulse output is registered and appears
// on the cycle after the access that caused it.
module dma_chan_regs
    import dma_chan_regs_pkg::*;
#(
    parameter int CH_W  = 5,
    parameter int OFS_W = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [CH_W+OFS_W-1:0] bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic                  bus_rvalid,
    input  logic                  kill_req,
    input  logic [CH_W-1:0]       kill_ch,
    output logic                  irq_pulse,
    output logic [CH_W-1:0]       irq_ch,
    output logic                  fetch_req,
    output logic [CH_W-1:0]       fetch_ch,
    output logic [WORD_W-1:0]     fetch_ptr,
    output logic                  start_pulse,
    output logic                  start_flush,
    output logic [CH_W-1:0]       start_ch
);

    localparam int NUM_CH = 1 << CH_W;

    logic [CH_W-1:0]   dec_ch;
    logic [IDX_W-1:0]  dec_idx;
    logic              dec_map;
    logic [WORD_W-1:0] rd_words [NUM_CH];
    logic [NUM_CH-1:0] fetch_v;
    logic [NUM_CH-1:0] start_v;
    logic [NUM_CH-1:0] flush_v;

    dma_chreg_decode #(.CH_W(CH_W), .OFS_W(OFS_W)) u_dec (
        .addr   (bus_addr),
        .ch     (dec_ch),
        .idx    (dec_idx),
        .mapped (dec_map)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dma_chreg_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_wr && dec_map && (dec_ch == CH_W'(g))),
            .wr_idx  (dec_idx),
            .wdata   (bus_wdata),
            .kill    (kill_req && (kill_ch == CH_W'(g))),
            .rd_idx  (dec_idx),
            .rd_word (rd_words[g]),
            .fetch_o (fetch_v[g]),
            .start_o (start_v[g]),
            .flush_o (flush_v[g])
        );
    end

    // Read return register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_rd;
            bus_rdata  <= (bus_rd && dec_map) ? rd_words[dec_ch] : '0;
        end
    end

    // Fetch, start and interrupt pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_req   <= 1'b0;
            fetch_ch    <= '0;
            fetch_ptr   <= '0;
            start_pulse <= 1'b0;
            start_flush <= 1'b0;
            start_ch    <= '0;
            irq_pulse   <= 1'b0;
            irq_ch      <= '0;
        end else begin
            fetch_req   <= |fetch_v;
            start_pulse <= |start_v;
            irq_pulse   <= kill_req;
            if (|fetch_v) begin
                fetch_ch  <= dec_ch;
                fetch_ptr <= {bus_wdata[WORD_W-1:4], 4'b0000};
            end
            if (|start_v) begin
                start_ch    <= dec_ch;
                start_flush <= flush_v[dec_ch];
            end
            if (kill_req) irq_ch <= kill_ch;
        end
    end

endmodule

// File: rtl/dma_chan_regs_chk.sv
// Module: dma_chan_regs_chk
// Port-level temporal checks for dma_chan_regs, attached with bind.
module dma_chan_regs_chk #(
    parameter int CH_W  = 5,
    parameter int OFS_W = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [CH_W+OFS_W-1:0] bus_addr,
    input logic                  bus_rvalid,
    input logic                  kill_req,
    input logic [CH_W-1:0]       kill_ch,
    input logic                  irq_pulse,
    input logic [CH_W-1:0]       irq_ch,
    input logic                  fetch_req,
    input logic [31:0]           fetch_ptr,
    input logic                  start_pulse,
    input logic [CH_W-1:0]       start_ch
);

    // R7: a fetch always carries a 16-byte aligned pointer
    p_fetch_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (fetch_ptr[3:0] == 4'd0));

    // R6: a fetch only follows a write to the pointer word
    p_fetch_from_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> ($past(bus_wr) && ($past(bus_addr[OFS_W-1:0]) == OFS_W'(12))));

    // R5: read strobe returns exactly one cycle later
    p_rvalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // R5: no stray read strobe
    p_no_stray_rvalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    // R9: a kill raises the interrupt for its own channel
    p_kill_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        kill_req |=> (irq_pulse && (irq_ch == $past(kill_ch))));

    // R8: a start only follows a write to the control word
    p_start_from_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> ($past(bus_wr) && ($past(bus_addr[OFS_W-1:0]) == '0)));

    // R9: a channel killed in the write cycle never starts
    p_start_not_killed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> !($past(kill_req) && ($past(kill_ch) == start_ch)));

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.CH_W(CH_W), .OFS_W(OFS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_rvalid  (bus_rvalid),
    .kill_req    (kill_req),
    .kill_ch     (kill_ch),
    .irq_pulse   (irq_pulse),
    .irq_ch      (irq_ch),
    .fetch_req   (fetch_req),
    .fetch_ptr   (fetch_ptr),
    .start_pulse (start_pulse),
    .start_ch    (start_ch)
);

// File: tb/dma_chan_regs_bench.sv
// Directed bench for dma_chan_regs: one task per scenario, each checking
// its own results against values worked out from the requirements.
module dma_chan_regs_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        kill_req = 1'b0;
    logic [4:0]  kill_ch = '0;
    logic        irq_pulse;
    logic [4:0]  irq_ch;
    logic        fetch_req;
    logic [4:0]  fetch_ch;
    logic [31:0] fetch_ptr;
    logic        start_pulse;
    logic        start_flush;
    logic [4:0]  start_ch;

    int checks = 0;
    int fails  = 0;

    // Outputs captured one cycle after each driven access
    logic        o_fetch, o_start, o_flush, o_irq, o_rvalid;
    logic [4:0]  o_fetch_ch, o_start_ch, o_irq_ch;
    logic [31:0] o_fetch_ptr, o_rdata;

    dma_chan_regs u_dma_chan_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_rvalid  (bus_rvalid),
        .kill_req    (kill_req),
        .kill_ch     (kill_ch),
        .irq_pulse   (irq_pulse),
        .irq_ch      (irq_ch),
        .fetch_req   (fetch_req),
        .fetch_ch    (fetch_ch),
        .fetch_ptr   (fetch_ptr),
        .start_pulse (start_pulse),
        .start_flush (start_flush),
        .start_ch    (start_ch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [11:0] waddr(input int ch, input int idx);
        return {ch[4:0], 1'b0, idx[3:0], 2'b00};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, req, what, act, exp);
    endtask

    // Drive one cycle from a negative edge, capture outputs at the next one
    task automatic cyc(input logic wr, input logic rd, input logic [11:0] a,
                       input logic [31:0] d, input logic k, input logic [4:0] kc);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        kill_req = k; kill_ch = kc;
        @(posedge clk);
        @(negedge clk);
        o_fetch = fetch_req; o_fetch_ch = fetch_ch; o_fetch_ptr = fetch_ptr;
        o_start = start_pulse; o_start_ch = start_ch; o_flush = start_flush;
        o_irq = irq_pulse; o_irq_ch = irq_ch;
        o_rvalid = bus_rvalid; o_rdata = bus_rdata;
        bus_wr = 1'b0; bus_rd = 1'b0; kill_req = 1'b0;
    endtask

    task automatic wr_reg(input int ch, input int idx, input logic [31:0] d);
        cyc(1'b1, 1'b0, waddr(ch, idx), d, 1'b0, 5'd0);
    endtask

    task automatic ctrl(input int ch, input logic [15:0] m, input logic [15:0] v);
        wr_reg(ch, 0, {m, v});
    endtask

    task automatic expect_reg(input int ch, input int idx, input logic [31:0] exp,
                              input string req);
        cyc(1'b0, 1'b1, waddr(ch, idx), '0, 1'b0, 5'd0);
        check_eq(req, $sformatf("rvalid ch%0d idx%0d", ch, idx), {31'd0, o_rvalid}, 32'd1);
        check_eq(req, $sformatf("read ch%0d idx%0d", ch, idx), o_rdata, exp);
    endtask

    // R1: reset state
    task automatic t_reset();
        check_eq("R1", "fetch after reset", {31'd0, fetch_req}, 0);
        check_eq("R1", "start after reset", {31'd0, start_pulse}, 0);
        check_eq("R1", "irq after reset", {31'd0, irq_pulse}, 0);
        for (int i = 0; i < 16; i++) expect_reg(0, i, 32'd0, "R1");
        expect_reg(31, 1, 32'd0, "R1");
        expect_reg(17, 3, 32'd0, "R1");
    endtask

    // R7: pointer load on an idle channel
    task automatic t_ptr_load();
        wr_reg(2, 3, 32'h1234_567F);
        check_eq("R7", "fetch pulse", {31'd0, o_fetch}, 1);
        check_eq("R7", "fetch channel", {27'd0, o_fetch_ch}, 2);
        check_eq("R7", "fetch pointer", o_fetch_ptr, 32'h1234_5670);
        expect_reg(2, 3, 32'h1234_5670, "R7");
        check_eq("R7", "fetch pulse is single", {31'd0, fetch_req}, 0);
    endtask

    // R5: plain, spare and zero-reading words
    task automatic t_plain_regs();
        for (int i = 2; i < 16; i++) begin
            if (i != 3) wr_reg(3, i, 32'hA5A5_0000 + i);
        end
        for (int i = 2; i < 16; i++) begin
            if (i == 4 || i == 5 || i == 6 || i == 10 || i >= 13)
                expect_reg(3, i, 32'hA5A5_0000 + i, "R5");
            else if (i != 3)
                expect_reg(3, i, 32'd0, "R5");
        end
        wr_reg(3, 0, 32'h00FF_0011);
        expect_reg(3, 0, 32'd0, "R5");
    endtask

    // R2: masked merge and settable bits
    task automatic t_ctrl_merge();
        ctrl(1, 16'h00FF, 16'h0042);
        check_eq("R2", "no start when inactive", {31'd0, o_start}, 0);
        expect_reg(1, 1, 32'h0000_0042, "R2");
        ctrl(1, 16'h000F, 16'h00F5);
        expect_reg(1, 1, 32'h0000_0045, "R2");
        ctrl(1, 16'h0F00, 16'h0F00);
        expect_reg(1, 1, 32'h0000_0045, "R2");
    endtask

    // R3, R4, R6, R8: run, pause, stop, wake and drain on channel 1
    task automatic t_run_cycle();
        ctrl(1, 16'h8000, 16'h8000);
        check_eq("R8", "start on RUN", {31'd0, o_start}, 1);
        check_eq("R8", "start channel", {27'd0, o_start_ch}, 1);
        check_eq("R8", "no drain", {31'd0, o_flush}, 0);
        expect_reg(1, 1, 32'h0000_8445, "R3");
        wr_reg(1, 3, 32'h0000_0100);
        check_eq("R6", "no fetch while running", {31'd0, o_fetch}, 0);
        expect_reg(1, 3, 32'd0, "R6");
        ctrl(1, 16'h4000, 16'h4000);
        check_eq("R3", "no start when paused", {31'd0, o_start}, 0);
        expect_reg(1, 1, 32'h0000_C045, "R3");
        wr_reg(1, 3, 32'h0000_0200);
        check_eq("R6", "no fetch while RUN and paused", {31'd0, o_fetch}, 0);
        ctrl(1, 16'hC000, 16'h0000);
        expect_reg(1, 1, 32'h0000_0045, "R4");
        ctrl(1, 16'h8000, 16'h8000);
        cyc(1'b0, 1'b0, '0, '0, 1'b1, 5'd1);
        check_eq("R9", "irq on kill", {31'd0, o_irq}, 1);
        check_eq("R9", "irq channel", {27'd0, o_irq_ch}, 1);
        expect_reg(1, 1, 32'h0000_8845, "R9");
        ctrl(1, 16'h8000, 16'h0000);
        check_eq("R4", "no start on stop", {31'd0, o_start}, 0);
        expect_reg(1, 1, 32'h0000_0045, "R4");
        ctrl(1, 16'h1000, 16'h1000);
        check_eq("R3", "start on WAKE", {31'd0, o_start}, 1);
        expect_reg(1, 1, 32'h0000_1445, "R3");
        wr_reg(1, 3, 32'h0000_0300);
        check_eq("R6", "no fetch while active", {31'd0, o_fetch}, 0);
        expect_reg(1, 3, 32'd0, "R6");
        ctrl(1, 16'h2000, 16'h2000);
        check_eq("R8", "start with drain", {31'd0, o_start}, 1);
        check_eq("R8", "drain flag", {31'd0, o_flush}, 1);
        expect_reg(1, 1, 32'h0000_3445, "R8");
    endtask

    // R9, R3: kill alone, kill then run, kill overlapping a write
    task automatic t_kill_overlap();
        cyc(1'b0, 1'b0, '0, '0, 1'b1, 5'd4);
        expect_reg(4, 1, 32'h0000_0800, "R9");
        ctrl(4, 16'h8000, 16'h8000);
        expect_reg(4, 1, 32'h0000_8400, "R3");
        cyc(1'b1, 1'b0, waddr(5, 0), 32'h8000_8000, 1'b1, 5'd5);
        check_eq("R9", "same-channel no start", {31'd0, o_start}, 0);
        check_eq("R9", "same-channel irq", {31'd0, o_irq}, 1);
        check_eq("R9", "same-channel irq ch", {27'd0, o_irq_ch}, 5);
        expect_reg(5, 1, 32'h0000_8800, "R9");
        cyc(1'b1, 1'b0, waddr(6, 0), 32'h8000_8000, 1'b1, 5'd7);
        check_eq("R9", "other-channel start", {31'd0, o_start}, 1);
        check_eq("R9", "other-channel start ch", {27'd0, o_start_ch}, 6);
        check_eq("R9", "other-channel irq ch", {27'd0, o_irq_ch}, 7);
        expect_reg(6, 1, 32'h0000_8400, "R9");
        expect_reg(7, 1, 32'h0000_0800, "R9");
    endtask

    // R10: unmapped offsets, misalignment and the top channel
    task automatic t_addressing();
        wr_reg(0, 4, 32'h0000_0011);
        cyc(1'b1, 1'b0, 12'h050, 32'h0000_0022, 1'b0, 5'd0);
        expect_reg(0, 4, 32'h0000_0011, "R10");
        cyc(1'b0, 1'b1, 12'h050, '0, 1'b0, 5'd0);
        check_eq("R10", "unmapped read", o_rdata, 32'd0);
        cyc(1'b1, 1'b0, 12'h04C, 32'h0000_0440, 1'b0, 5'd0);
        check_eq("R10", "unmapped pointer no fetch", {31'd0, o_fetch}, 0);
        cyc(1'b1, 1'b0, 12'h011, 32'h0000_0033, 1'b0, 5'd0);
        expect_reg(0, 4, 32'h0000_0011, "R10");
        wr_reg(31, 3, 32'hFFFF_FFFF);
        check_eq("R10", "top channel fetch ch", {27'd0, o_fetch_ch}, 31);
        check_eq("R10", "top channel ptr", o_fetch_ptr, 32'hFFFF_FFF0);
        expect_reg(30, 3, 32'd0, "R10");
    endtask

    // R11: direct status write
    task automatic t_status_direct();
        wr_reg(8, 1, 32'hDEAD_BEEF);
        expect_reg(8, 1, 32'h0000_BEEF, "R11");
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ptr_load();
        t_plain_regs();
        t_ctrl_merge();
        t_run_cycle();
        t_kill_overlap();
        t_addressing();
        t_status_direct();
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

endmodule